// File: doc/BRIEF.md
# Mode Register Write Engine with Rank Mirroring

This block issues mode-register-set commands toward a DDR4 command scheduler. A sequencer or register front end hands it one request at a time: a mode register number, a data word, a command type and a one-hot rank select. The engine accepts a request only while no earlier mode-register transaction is outstanding. It remaps the request for address-mirrored second-rank devices, packs it into a command word with a self-clearing launch bit, and holds a busy flag until the command side reports completion.

A batch mode reprograms a whole set of mode registers after a frequency change. A small internal table holds, for each performance state, eight 17-bit entries. On a batch start the engine walks every rank from the first to the configured count. For each rank it writes registers 0 to 5 from entries 0 to 5, then register 6 from entry 7, and raises a one-cycle done pulse when the last write completes. The same mirroring rule is applied to every batch command.

Top module: `mrw_engine`

## Requirements
- R1: After reset `busy`, `cmd_valid` and `batch_done` are 0 and `req_ready` is 1.
- R2: A single request (`req_valid`) is accepted only on a clock edge where the engine is idle. A `req_valid` seen while busy, including during a batch, launches no command. If `batch_start` and `req_valid` are both present at an idle edge, the batch wins.
- R3: `cmd_valid` is high for exactly one cycle, starting the cycle after acceptance. The command word carries the type in bits 3:0, the rank select in bits 5:4 and the (possibly mirrored) register number in bits 14:12, with all other bits 0. Bit 31 is 1 only in the launch cycle. `cmd_data` carries the (possibly mirrored) 17-bit data word.
- R4: `busy` is 1 from the launch cycle through the edge at which `cmd_done` is sampled while a command is outstanding, and 0 from the following cycle. A `cmd_done` in the launch cycle or while idle is ignored.
- R5: Mirroring is applied only when `mirror_en` is 1 and the rank select equals 2'b10. Otherwise register number and data pass unchanged.
- R6: When mirroring, register-number bits 0 and 1 are exchanged and bit 2 keeps its place.
- R7: When mirroring, data bits 3/4, 5/6, 7/8 and 11/13 are exchanged. Bits 0, 1, 2, 9, 10, 12 and 14 to 16 keep their places.
- R8: A batch uses the table row chosen by `batch_pstate`. For rank k = 1 to `batch_ranks` (0 counts as 1) it issues registers 0 to 5 from entries 0 to 5, then register 6 from entry 7. Each batch command uses type 0 and rank select 2'b01 for k=1 and 2'b10 for k=2.
- R9: `batch_done` is a one-cycle pulse in the first cycle after the last batch command's `cmd_done` is sampled, and `busy` is 0 in that cycle.
- R10: `tbl_we` writes `tbl_wdata` into table row `tbl_pstate`, entry `tbl_entry`. Later batches use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mirror_en | input | 1 | Second-rank address mirroring enable |
| req_valid | input | 1 | Single mode-register request |
| req_type | input | 4 | Command type for the request |
| req_rank | input | 2 | One-hot rank select |
| req_mr | input | 3 | Mode register number |
| req_data | input | 17 | Mode register data |
| req_ready | output | 1 | Engine idle, request can be taken |
| batch_start | input | 1 | Start a batch walk |
| batch_pstate | input | 2 | Table row for the batch |
| batch_ranks | input | 2 | Number of ranks to walk |
| tbl_we | input | 1 | Table write strobe |
| tbl_pstate | input | 2 | Table write row |
| tbl_entry | input | 3 | Table write entry |
| tbl_wdata | input | 17 | Table write data |
| cmd_valid | output | 1 | One-cycle launch strobe |
| cmd_word | output | 32 | Packed command word, bit 31 is the launch bit |
| cmd_data | output | 17 | Data word for the command |
| cmd_done | input | 1 | Command side reports completion |
| busy | output | 1 | Transaction outstanding |
| batch_done | output | 1 | Batch finished pulse |

## Verification
The bench sweeps every register number against both rank selects with mirroring on and off, and walks a single 1 across all 17 data bits. A wrong mirror condition, a missed or extra bit swap, or a misplaced field therefore shows as a mismatched command word or data word. It drives `cmd_done` in the launch cycle and while idle, and asserts `req_valid` while busy and during a batch. A design that ends a transaction early or takes a request too soon then shows a dropped busy or an extra launch. Batches over every table row with one and two ranks check the order of registers and entries, with entry 6 skipped, and the rank encoding. They also check that the done pulse falls exactly on the cycle busy drops.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  localparam int MR_W       = 3;
  localparam int DATA_W     = 17;
  localparam int TYPE_W     = 4;
  localparam int RANK_W     = 2;
  localparam int PSTATE_N   = 4;
  localparam int ENTRY_N    = 8;
  localparam int BATCH_MR_N = 7;
  localparam int WORD_W     = 32;
  localparam int RANK_LSB   = 4;
  localparam int MR_LSB     = 12;
  localparam int TRIG_BIT   = 31;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ISSUE, S_WAIT} mrw_state_e;

  function automatic logic mirror_hit(input logic en, input logic [RANK_W-1:0] rank);
    return en && (rank == 2'b10);
  endfunction

  function automatic logic [MR_W-1:0] mirror_mr(input logic [MR_W-1:0] mr);
    logic [MR_W-1:0] r;
    r = mr;
    r[0] = mr[1];
    r[1] = mr[0];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] mirror_data(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[3]  = d[4];  r[4]  = d[3];
    r[5]  = d[6];  r[6]  = d[5];
    r[7]  = d[8];  r[8]  = d[7];
    r[11] = d[13]; r[13] = d[11];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cmd(input logic [TYPE_W-1:0] t,
                                                 input logic [RANK_W-1:0] rk,
                                                 input logic [MR_W-1:0] mr);
    logic [WORD_W-1:0] w;
    w = '0;
    w[TYPE_W-1:0] = t;
    w[RANK_LSB +: RANK_W] = rk;
    w[MR_LSB +: MR_W] = mr;
    return w;
  endfunction

  function automatic logic [2:0] batch_entry(input logic [2:0] step);
    return (int'(step) < BATCH_MR_N - 1) ? step : 3'(ENTRY_N - 1);
  endfunction
endpackage

// File: rtl/mrw_mirror.sv
module mrw_mirror
  import mrw_pkg::*;
(
  input  logic              mirror_en,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [MR_W-1:0]   mr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic [DATA_W-1:0] data_o
);
  logic            do_mirror;
  logic [MR_W-1:0] mr_sel;

  always_comb begin
    do_mirror = mirror_hit(mirror_en, rank_i);
    mr_sel    = do_mirror ? mirror_mr(mr_i) : mr_i;
    data_o    = do_mirror ? mirror_data(data_i) : data_i;
    word_o    = pack_cmd(type_i, rank_i, mr_sel);
  end

  // Exchanged bits must come back to place when applied twice (R7, R6)
  always_comb begin
    if (do_mirror) begin
      a_data_involution_r7: assert (mirror_data(data_o) == data_i);
      a_mr_involution_r6: assert (mirror_mr(mr_sel) == mr_i);
    end
  end
endmodule

// File: rtl/mrw_table.sv
module mrw_table
  import mrw_pkg::*;
#(
  parameter int ROWS  = PSTATE_N,
  parameter int COLS  = ENTRY_N,
  parameter int WIDTH = DATA_W,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RW-1:0]    wrow,
  input  logic [CW-1:0]    wcol,
  input  logic [WIDTH-1:0] wdata,
  input  logic [RW-1:0]    rrow,
  input  logic [CW-1:0]    rcol,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n) mem[r][c] <= '0;
        else if (we && wrow == RW'(r) && wcol == CW'(c)) mem[r][c] <= wdata;
      end
    end
  end

  assign rdata = mem[rrow][rcol];

  p_table_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wrow)][$past(wcol)] == $past(wdata));
endmodule

// File: rtl/mrw_batch_seq.sv
module mrw_batch_seq
  import mrw_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  parameter int STEPS     = BATCH_MR_N,
  localparam int KW = $clog2(MAX_RANKS + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [KW-1:0]     ranks_cfg,
  output logic [2:0]        step_o,
  output logic [2:0]        entry_o,
  output logic [RANK_W-1:0] rank_sel_o,
  output logic              last_o
);
  logic [2:0]    step_q;
  logic [KW-1:0] rank_q;
  logic [KW-1:0] ranks_q;
  logic          last_rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= '0;
      rank_q  <= KW'(1);
      ranks_q <= KW'(1);
    end else if (start) begin
      step_q  <= '0;
      rank_q  <= KW'(1);
      ranks_q <= ranks_cfg;
    end else if (advance) begin
      if (int'(step_q) == STEPS - 1) begin
        step_q <= '0;
        rank_q <= rank_q + KW'(1);
      end else begin
        step_q <= step_q + 3'd1;
      end
    end
  end

  always_comb begin
    last_rank  = (rank_q >= ranks_q) || (int'(rank_q) == MAX_RANKS);
    last_o     = last_rank && (int'(step_q) == STEPS - 1);
    step_o     = step_q;
    entry_o    = batch_entry(step_q);
    rank_sel_o = RANK_W'(1) << (rank_q - KW'(1));
  end

  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) < STEPS);
  p_rank_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rank_q != '0 && int'(rank_q) <= MAX_RANKS);
endmodule

// File: rtl/mrw_engine.sv
module mrw_engine
  import mrw_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  localparam int PW = $clog2(PSTATE_N),
  localparam int EW = $clog2(ENTRY_N),
  localparam int KW = $clog2(MAX_RANKS + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mirror_en,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [MR_W-1:0]   req_mr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  input  logic              batch_start,
  input  logic [PW-1:0]     batch_pstate,
  input  logic [KW-1:0]     batch_ranks,
  input  logic              tbl_we,
  input  logic [PW-1:0]     tbl_pstate,
  input  logic [EW-1:0]     tbl_entry,
  input  logic [DATA_W-1:0] tbl_wdata,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_done,
  output logic              busy,
  output logic              batch_done
);
  mrw_state_e        state_q;
  logic              batch_q;
  logic              done_q;
  logic [PW-1:0]     pstate_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic              take_req;
  logic              take_batch;
  logic              finish_cmd;
  logic              seq_advance;
  logic              seq_last;

  logic [2:0]        seq_step;
  logic [2:0]        seq_entry;
  logic [RANK_W-1:0] seq_rank;
  logic [DATA_W-1:0] tbl_rdata;

  logic [TYPE_W-1:0] src_type;
  logic [RANK_W-1:0] src_rank;
  logic [MR_W-1:0]   src_mr;
  logic [DATA_W-1:0] src_data;
  logic [WORD_W-1:0] mir_word;
  logic [DATA_W-1:0] mir_data;

  assign take_batch  = (state_q == S_IDLE) && batch_start;
  assign take_req    = (state_q == S_IDLE) && !batch_start && req_valid;
  assign finish_cmd  = (state_q == S_WAIT) && cmd_done;
  assign seq_advance = finish_cmd && batch_q && !seq_last;

  mrw_table #(.ROWS(PSTATE_N), .COLS(ENTRY_N), .WIDTH(DATA_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .wrow  (tbl_pstate),
    .wcol  (tbl_entry),
    .wdata (tbl_wdata),
    .rrow  (pstate_q),
    .rcol  (seq_entry),
    .rdata (tbl_rdata)
  );

  mrw_batch_seq #(.MAX_RANKS(MAX_RANKS), .STEPS(BATCH_MR_N)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take_batch),
    .advance    (seq_advance),
    .ranks_cfg  (batch_ranks),
    .step_o     (seq_step),
    .entry_o    (seq_entry),
    .rank_sel_o (seq_rank),
    .last_o     (seq_last)
  );

  always_comb begin
    if (state_q == S_PREP) begin
      src_type = '0;
      src_rank = seq_rank;
      src_mr   = MR_W'(seq_step);
      src_data = tbl_rdata;
    end else begin
      src_type = req_type;
      src_rank = req_rank;
      src_mr   = req_mr;
      src_data = req_data;
    end
  end

  mrw_mirror u_mirror (
    .mirror_en (mirror_en),
    .type_i    (src_type),
    .rank_i    (src_rank),
    .mr_i      (src_mr),
    .data_i    (src_data),
    .word_o    (mir_word),
    .data_o    (mir_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      batch_q  <= 1'b0;
      done_q   <= 1'b0;
      pstate_q <= '0;
      word_q   <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (take_batch) begin
            batch_q  <= 1'b1;
            pstate_q <= batch_pstate;
            state_q  <= S_PREP;
          end else if (take_req) begin
            word_q  <= mir_word;
            data_q  <= mir_data;
            state_q <= S_ISSUE;
          end
        end
        S_PREP: begin
          word_q  <= mir_word;
          data_q  <= mir_data;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (finish_cmd) begin
            if (batch_q && !seq_last) begin
              state_q <= S_PREP;
            end else begin
              done_q  <= batch_q;
              batch_q <= 1'b0;
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid  = (state_q == S_ISSUE);
    cmd_word   = word_q;
    cmd_word[TRIG_BIT] = cmd_valid;
    cmd_data   = data_q;
    busy       = (state_q != S_IDLE);
    req_ready  = (state_q == S_IDLE);
    batch_done = done_q;
  end

  p_trig_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_busy_at_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !cmd_done) |=> busy);
  p_launch_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> ($past(state_q) == S_IDLE || $past(state_q) == S_PREP));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> (!busy && $past(finish_cmd)));
endmodule

// File: tb/mrw_engine_bench.sv
module mrw_engine_bench;
  import mrw_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mirror_en = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_type = '0;
  logic [1:0] req_rank = '0;
  logic [2:0] req_mr = '0;
  logic [16:0] req_data = '0;
  logic req_ready;
  logic batch_start = 1'b0;
  logic [1:0] batch_pstate = '0;
  logic [1:0] batch_ranks = '0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_pstate = '0;
  logic [2:0] tbl_entry = '0;
  logic [16:0] tbl_wdata = '0;
  logic cmd_valid;
  logic [31:0] cmd_word;
  logic [16:0] cmd_data;
  logic cmd_done = 1'b0;
  logic busy;
  logic batch_done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mrw_engine u_mrw_engine (
    .clk(clk), .rst_n(rst_n), .mirror_en(mirror_en),
    .req_valid(req_valid), .req_type(req_type), .req_rank(req_rank),
    .req_mr(req_mr), .req_data(req_data), .req_ready(req_ready),
    .batch_start(batch_start), .batch_pstate(batch_pstate), .batch_ranks(batch_ranks),
    .tbl_we(tbl_we), .tbl_pstate(tbl_pstate), .tbl_entry(tbl_entry), .tbl_wdata(tbl_wdata),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .busy(busy), .batch_done(batch_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench's own model of the remapping: table of exchanged positions
  function automatic logic [16:0] swap_model(input logic [16:0] d);
    int lo [4] = '{3, 5, 7, 11};
    int hi [4] = '{4, 6, 8, 13};
    logic [16:0] r = d;
    for (int k = 0; k < 4; k++) begin
      r[lo[k]] = d[hi[k]];
      r[hi[k]] = d[lo[k]];
    end
    return r;
  endfunction

  function automatic logic [31:0] word_model(input logic [3:0] t, input logic [1:0] rk,
                                             input logic [2:0] mr, input logic mir);
    logic [2:0] m = mir ? {mr[2], mr[0], mr[1]} : mr;
    return 32'(t) + (32'(rk) * 32'd16) + (32'(m) * 32'd4096);
  endfunction

  function automatic logic [16:0] tbl_val(input int p, input int e);
    return 17'((p * 8 + e) * 32'h2d35 + 32'h1a5 * e + 7);
  endfunction

  // wait for a launch, check it, then complete it after dly cycles
  task automatic serve(input string req, input logic [31:0] exp_w, input logic [16:0] exp_d,
                       input int dly);
    int n = 0;
    while (!cmd_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check({req, " launch"}, 32'(cmd_valid), 32'd1);
    check({req, " word"}, cmd_word, exp_w | 32'h8000_0000);
    check({req, " data"}, 32'(cmd_data), 32'(exp_d));
    @(negedge clk);
    check("R3 trigger clears", {31'd0, cmd_word[31]}, 32'd0);
    for (int k = 1; k < dly; k++) @(negedge clk);
    check("R4 busy held", 32'(busy), 32'd1);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic single(input logic [3:0] t, input logic [1:0] rk, input logic [2:0] mr,
                        input logic [16:0] d, input logic men);
    logic mir = men && rk == 2'b10;
    mirror_en = men;
    req_type = t; req_rank = rk; req_mr = mr; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 one cycle after accept", 32'(cmd_valid), 32'd1);
    serve("R5 R6 R7 single", word_model(t, rk, mr, mir), mir ? swap_model(d) : d, 1 + int'(mr[1:0]));
    check("R4 busy drops", 32'(busy), 32'd0);
  endtask

  task automatic run_batch(input int p, input int nr, input logic men, input logic poke);
    int ranks = (nr == 0) ? 1 : nr;
    mirror_en = men;
    batch_pstate = 2'(p); batch_ranks = 2'(nr); batch_start = 1'b1;
    req_valid = poke; req_type = 4'hf; req_rank = 2'b01; req_mr = 3'd5; req_data = 17'h1ffff;
    @(negedge clk);
    batch_start = 1'b0;
    for (int r = 1; r <= ranks; r++) begin
      for (int s = 0; s < 7; s++) begin
        logic [1:0] rk = (r == 1) ? 2'b01 : 2'b10;
        logic mir = men && rk == 2'b10;
        int e = (s == 6) ? 7 : s;
        serve("R8 batch", word_model(4'd0, rk, 3'(s), mir),
              mir ? swap_model(tbl_val(p, e)) : tbl_val(p, e), 1 + (s % 2));
        if (r == ranks && s == 6) begin
          req_valid = 1'b0;
          check("R9 done pulse", 32'(batch_done), 32'd1);
          check("R9 idle at done", 32'(busy), 32'd0);
        end else begin
          check("R9 no early done", 32'(batch_done), 32'd0);
        end
      end
    end
    @(negedge clk);
    check("R9 done one cycle", 32'(batch_done), 32'd0);
    check("R2 no extra launch", 32'(cmd_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    check("R1 batch_done", 32'(batch_done), 32'd0);
    check("R1 ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 sweep: every register number, both ranks, mirror on/off
    for (int m = 0; m < 8; m++)
      for (int rk = 1; rk <= 2; rk++)
        for (int men = 0; men < 2; men++)
          single(4'(m + rk), 2'(rk), 3'(m), 17'(32'h15a5a >> m), 1'(men));

    // R7 walking one across data bits, rank 2 mirrored and rank 1 with enable set
    for (int b = 0; b < 17; b++) begin
      single(4'd0, 2'b10, 3'd0, 17'(1) << b, 1'b1);
      single(4'd3, 2'b01, 3'd3, 17'(1) << b, 1'b1);
    end

    // R4 done while idle is ignored, done in launch cycle is ignored
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    check("R4 idle done", 32'(busy), 32'd0);
    req_type = 4'h2; req_rank = 2'b01; req_mr = 3'd4; req_data = 17'h00abc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    check("R4 launch-cycle done ignored", 32'(busy), 32'd1);
    // R2 request while busy is not taken
    req_type = 4'h1; req_rank = 2'b10; req_mr = 3'd1; req_data = 17'h1; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    check("R2 ready low while busy", 32'(req_ready), 32'd0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    check("R4 busy drops", 32'(busy), 32'd0);
    repeat (3) begin
      @(negedge clk);
      check("R2 busy request dropped", 32'(cmd_valid), 32'd0);
    end

    // R10 fill the table
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 8; e++) begin
        tbl_we = 1'b1; tbl_pstate = 2'(p); tbl_entry = 3'(e); tbl_wdata = tbl_val(p, e);
        @(negedge clk);
      end
    tbl_we = 1'b0;

    // R8 R9 batches over all rows, one and two ranks, request poked (R2)
    for (int p = 0; p < 4; p++)
      for (int nr = 0; nr <= 2; nr++)
        run_batch(p, nr, 1'(p % 2), 1'(nr == 2));

    // R10 overwrite one entry and rerun
    tbl_we = 1'b1; tbl_pstate = 2'd2; tbl_entry = 3'd7; tbl_wdata = 17'h0;
    @(negedge clk);
    tbl_we = 1'b0;
    mirror_en = 1'b0;
    batch_pstate = 2'd2; batch_ranks = 2'd1; batch_start = 1'b1;
    @(negedge clk);
    batch_start = 1'b0;
    for (int s = 0; s < 7; s++)
      serve("R10 batch after write", word_model(4'd0, 2'b01, 3'(s), 1'b0),
            (s == 6) ? 17'h0 : tbl_val(2, s), 1);
    check("R9 done after rewrite", 32'(batch_done), 32'd1);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule